// File: doc/BRIEF.md
# Interrupt Vector Resolver with Read Acknowledge

This block holds the selection and acknowledge logic behind the two vector registers of a 64-source interrupt controller. It takes the pending, enable and fast-type vectors, plus a 4-bit priority for each source, from the controller's register storage. It then resolves two answers in parallel, both combinational: the best normal-type candidate and the first fast-type candidate.

A bus read of either vector register raises `rd_i`, and `rd_sel_i` picks the register. The block returns the packed vector word in the same cycle. While the read is active and a source was found, it also raises a one-hot clear strobe for that source's pending bit. The surrounding controller applies the strobe at the clock edge that ends the read. Because of this, a read in the very next cycle already sees the acknowledged source removed.

Top module: `irq_vector_resolver`

## Requirements
- R1: A source is a normal candidate only when its pending bit is 1, its enable bit is 1 and its fast-type bit is 0. Any other source is never returned or cleared by a normal read (`rd_sel_i` = 0).
- R2: Among the normal candidates the largest 4-bit priority wins. Source s takes its priority from `prio_i[4s+3:4s]`. When priorities tie, the higher-numbered source wins.
- R3: When a normal candidate exists, the word on `rdata_o` for `rd_sel_i` = 0 carries the winning source number in bits 31:16, zeros in bits 15:4 and its priority in bits 3:0.
- R4: With no normal candidate, a normal read returns 32'hFFFFFFFF and `clr_o` stays all zero. This includes the state during and right after reset.
- R5: For `rd_sel_i` = 1, `rdata_o` is the zero-extended number of the lowest-numbered source whose pending, enable and fast-type bits are all 1. Priority plays no part in this choice.
- R6: With no fast candidate, a fast read returns 32'hFFFFFFFF and `clr_o` stays all zero.
- R7: `clr_o` has at most one bit set. Its only set bit is the returned source, and only while `rd_i` is 1 and a source was found. When `rd_i` is 0, `clr_o` is all zero.
- R8: `rdata_o` and `clr_o` depend only on the present inputs. Once the controller has applied a clear at the end of one read, a read in the next cycle returns the next source of either type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the embedded property checks |
| rst | input | 1 | Synchronous active-high reset, disables the property checks |
| pend_i | input | 64 | Pending bit per source |
| en_i | input | 64 | Enable bit per source |
| fast_i | input | 64 | 1 = source is fast-type, 0 = normal-type |
| prio_i | input | 256 | 4-bit priority per source, source s at bits 4s+3:4s |
| rd_i | input | 1 | A vector register is being read this cycle |
| rd_sel_i | input | 1 | 0 = normal vector register, 1 = fast vector register |
| rdata_o | output | 32 | Vector word for the selected register |
| clr_o | output | 64 | One-hot pending-clear strobe for the acknowledged source |

## Verification
The selection logic is exercised with several kinds of input pattern, and each pattern rules out a different fault:
- Single candidates mixed with sources that are only pending, only enabled, or fast-typed. These separate the candidate filter from the selection trees.
- Equal priorities on every source. This exposes a tie rule that favours the lower number.
- Hand-picked priority orders. These catch a comparison that goes the wrong way.
- Full pending vectors drained by back-to-back reads of one register, and then of both registers alternately. These show that every cycle picks from the state left by the previous acknowledge, and that the two registers never take a source of the other type.
- Long random runs. These mix all of the above, including reads with nothing to return and cycles with no read.

// File: rtl/vr_pkg.sv
package vr_pkg;

    localparam int SRC_N   = 64;
    localparam int PRIO_W  = 4;
    localparam int IDX_W   = $clog2(SRC_N);
    localparam int WORD_W  = 32;
    localparam int IDX_LSB = 16;

    typedef struct packed {
        logic              valid;
        logic [PRIO_W-1:0] prio;
        logic [IDX_W-1:0]  idx;
    } cand_t;

    typedef enum logic {
        SEL_NORM = 1'b0,
        SEL_FAST = 1'b1
    } vsel_e;

    // Priority merge: the upper half wins on greater or equal priority,
    // which makes ties go to the higher-numbered source.
    function automatic cand_t merge_prio(cand_t lo, cand_t hi);
        if (hi.valid && (!lo.valid || hi.prio >= lo.prio)) begin
            return hi;
        end
        return lo;
    endfunction

    // First-found merge: the lower half wins whenever it has a candidate.
    function automatic cand_t merge_first(cand_t lo, cand_t hi);
        return lo.valid ? lo : hi;
    endfunction

    function automatic logic [WORD_W-1:0] pack_norm(cand_t c);
        logic [WORD_W-1:0] w;
        w = '1;
        if (c.valid) begin
            w = '0;
            w[IDX_LSB +: IDX_W] = c.idx;
            w[PRIO_W-1:0]       = c.prio;
        end
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] pack_fast(cand_t c);
        logic [WORD_W-1:0] w;
        w = '1;
        if (c.valid) begin
            w = '0;
            w[IDX_W-1:0] = c.idx;
        end
        return w;
    endfunction

endpackage

// File: rtl/vr_tree.sv
module vr_tree
    import vr_pkg::*;
#(
    parameter int N            = SRC_N,
    parameter bit LOWEST_FIRST = 1'b0
) (
    input  logic [N-1:0]        cand_i,
    input  logic [N*PRIO_W-1:0] prio_i,
    output cand_t               win_o
);

    localparam int LVL = $clog2(N);

    // Balanced binary reduction, one generate block per level.
    for (genvar l = 0; l <= LVL; l++) begin : g_lvl
        localparam int W = N >> l;
        cand_t nd [W];
        if (l == 0) begin : g_leaf
            for (genvar i = 0; i < W; i++) begin : g_src
                assign nd[i] = {cand_i[i], prio_i[i*PRIO_W +: PRIO_W], IDX_W'(i)};
            end
        end else begin : g_node
            for (genvar i = 0; i < W; i++) begin : g_cmb
                if (LOWEST_FIRST) begin : g_first
                    assign nd[i] = merge_first(g_lvl[l-1].nd[2*i], g_lvl[l-1].nd[2*i+1]);
                end else begin : g_prio
                    assign nd[i] = merge_prio(g_lvl[l-1].nd[2*i], g_lvl[l-1].nd[2*i+1]);
                end
            end
        end
    end

    assign win_o = g_lvl[LVL].nd[0];

endmodule

// File: rtl/vr_ack.sv
module vr_ack
    import vr_pkg::*;
#(
    parameter int N = SRC_N
) (
    input  cand_t             norm_win_i,
    input  cand_t             fast_win_i,
    input  logic              rd_i,
    input  vsel_e             sel_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic [N-1:0]      clr_o
);

    cand_t chosen;

    always_comb begin
        chosen  = (sel_i == SEL_FAST) ? fast_win_i : norm_win_i;
        rdata_o = (sel_i == SEL_FAST) ? pack_fast(fast_win_i) : pack_norm(norm_win_i);
        clr_o   = '0;
        if (rd_i && chosen.valid) begin
            clr_o[chosen.idx] = 1'b1;
        end
    end

endmodule

// File: rtl/irq_vector_resolver.sv
module irq_vector_resolver
    import vr_pkg::*;
#(
    parameter int N_SRC = SRC_N
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_SRC-1:0]        pend_i,
    input  logic [N_SRC-1:0]        en_i,
    input  logic [N_SRC-1:0]        fast_i,
    input  logic [N_SRC*PRIO_W-1:0] prio_i,
    input  logic                    rd_i,
    input  logic                    rd_sel_i,
    output logic [WORD_W-1:0]       rdata_o,
    output logic [N_SRC-1:0]        clr_o
);

    logic [N_SRC-1:0] live;
    logic [N_SRC-1:0] norm_cand;
    logic [N_SRC-1:0] fast_cand;
    cand_t            norm_win;
    cand_t            fast_win;
    vsel_e            sel;

    assign live      = pend_i & en_i;
    assign norm_cand = live & ~fast_i;
    assign fast_cand = live & fast_i;
    assign sel       = vsel_e'(rd_sel_i);

    vr_tree #(.N(N_SRC), .LOWEST_FIRST(1'b0)) u_norm_tree (
        .cand_i (norm_cand),
        .prio_i (prio_i),
        .win_o  (norm_win)
    );

    vr_tree #(.N(N_SRC), .LOWEST_FIRST(1'b1)) u_fast_tree (
        .cand_i (fast_cand),
        .prio_i (prio_i),
        .win_o  (fast_win)
    );

    vr_ack #(.N(N_SRC)) u_ack (
        .norm_win_i (norm_win),
        .fast_win_i (fast_win),
        .rd_i       (rd_i),
        .sel_i      (sel),
        .rdata_o    (rdata_o),
        .clr_o      (clr_o)
    );

    // R7: never more than one source acknowledged
    a_r7_clr_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr_o));

    // R7: no strobe outside a read
    a_r7_idle_no_clr: assert property (@(posedge clk) disable iff (rst)
        !rd_i |-> clr_o == '0);

    // R1: a normal read only clears a live normal-type source
    a_r1_norm_clear_type: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !rd_sel_i) |-> (clr_o & (fast_i | ~pend_i | ~en_i)) == '0);

    // R5: a fast read only clears a live fast-type source
    a_r5_fast_clear_type: assert property (@(posedge clk) disable iff (rst)
        (rd_i && rd_sel_i) |-> (clr_o & (~fast_i | ~pend_i | ~en_i)) == '0);

    // R4 / R6: the empty word never comes with a strobe
    a_r4_empty_no_clr: assert property (@(posedge clk) disable iff (rst)
        (rdata_o == '1) |-> clr_o == '0);

    // R3: a found normal word keeps its middle bits zero
    a_r3_norm_pack: assert property (@(posedge clk) disable iff (rst)
        (!rd_sel_i && rdata_o != '1) |-> rdata_o[IDX_LSB-1:PRIO_W] == '0);

endmodule

// File: tb/irq_vector_resolver_test.sv
`timescale 1ns/1ps
module irq_vector_resolver_test;

    localparam int N = 64;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N-1:0]   pend = '0;
    logic [N-1:0]   en_i = '0;
    logic [N-1:0]   fast_i = '0;
    logic [4*N-1:0] prio_i = '0;
    logic           rd_i = 1'b0;
    logic           rd_sel_i = 1'b0;
    logic [31:0]    rdata_o;
    logic [N-1:0]   clr_o;

    logic           load_req = 1'b0;
    logic [N-1:0]   load_val = '0;
    string          phase = "R4";
    int             n_cmp = 0;
    int             n_bad = 0;
    bit             done = 1'b0;

    always #4 clk = ~clk;

    irq_vector_resolver uut (
        .clk(clk), .rst(rst), .pend_i(pend), .en_i(en_i), .fast_i(fast_i),
        .prio_i(prio_i), .rd_i(rd_i), .rd_sel_i(rd_sel_i),
        .rdata_o(rdata_o), .clr_o(clr_o)
    );

    // Pending storage of the surrounding controller, modelled in the bench.
    always @(posedge clk) begin
        if (rst)           pend <= '0;
        else if (load_req) pend <= load_val;
        else               pend <= pend & ~clr_o;
    end

    // Behavioural reference for one read.
    task automatic model(output logic [31:0] w, output logic [N-1:0] c, output bit found);
        int best = -1;
        int bp = -1;
        for (int s = 0; s < N; s++) begin
            if (pend[s] && en_i[s] && (fast_i[s] == rd_sel_i)) begin
                if (rd_sel_i) begin
                    if (best < 0) best = s;
                end else if (int'(prio_i[4*s +: 4]) >= bp) begin
                    bp = int'(prio_i[4*s +: 4]);
                    best = s;
                end
            end
        end
        found = (best >= 0);
        if (!found)        w = 32'hFFFF_FFFF;
        else if (rd_sel_i) w = 32'(best);
        else               w = (32'(best) << 16) | 32'(bp);
        c = (rd_i && found) ? (64'd1 << best) : '0;
    endtask

    always @(negedge clk) begin
        logic [31:0] ew;
        logic [N-1:0] ec;
        bit f;
        string tag;
        if (!done) begin
            model(ew, ec, f);
            tag = rd_sel_i ? (f ? "R5" : "R6") : (f ? "R2" : "R4");
            n_cmp++;
            if (rdata_o !== ew) begin
                n_bad++;
                $display("FAIL %s (%s) rdata got %h expected %h", tag, phase, rdata_o, ew);
            end
            n_cmp++;
            if (clr_o !== ec) begin
                n_bad++;
                $display("FAIL R7 (%s) clr got %h expected %h", phase, clr_o, ec);
            end
        end
    end

    task automatic cyc(input logic rd, input logic sel);
        @(posedge clk); #1;
        rd_i = rd; rd_sel_i = sel;
    endtask

    task automatic load(input logic [N-1:0] v);
        @(posedge clk); #1;
        load_req = 1'b1; load_val = v; rd_i = 1'b0;
        @(posedge clk); #1;
        load_req = 1'b0;
    endtask

    function automatic logic [4*N-1:0] rnd_prio();
        logic [4*N-1:0] p;
        for (int k = 0; k < 8; k++) p[32*k +: 32] = $urandom;
        return p;
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R4: reset state, nothing pending
        rd_i = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        cyc(1, 0); cyc(1, 1);

        // R1: pending-only, enabled-only and fast-typed sources are not normal candidates
        phase = "R1";
        en_i = 64'h0000_0000_0000_00F0; fast_i = 64'h0000_0000_0000_0030;
        prio_i = rnd_prio();
        load(64'h0000_0000_0000_0F3C);
        cyc(0, 0); cyc(0, 1); cyc(1, 0); cyc(1, 0); cyc(1, 0);

        // R2: equal priorities, higher index must win
        phase = "R2";
        en_i = '1; fast_i = '0;
        for (int s = 0; s < N; s++) prio_i[4*s +: 4] = 4'h7;
        load(64'h8000_0000_0001_0001);
        cyc(0, 0); cyc(1, 0); cyc(1, 0); cyc(1, 0); cyc(1, 0);

        // R3: distinct priorities, packing of index and priority
        phase = "R3";
        prio_i = '0;
        prio_i[4*5 +: 4] = 4'hF; prio_i[4*40 +: 4] = 4'h3; prio_i[4*63 +: 4] = 4'hE;
        load(64'h8000_0100_0000_0021);
        repeat (5) cyc(1, 0);

        // R5: fast vector ignores priority, lowest index first
        phase = "R5";
        fast_i = 64'hF000_0000_0000_0F00; prio_i = rnd_prio();
        load('1);
        repeat (10) cyc(1, 1);

        // R6: fast-typed but disabled sources are not returned
        phase = "R6";
        en_i = ~fast_i;
        load('1);
        cyc(1, 1); cyc(1, 1);

        // R7: no read, no strobe
        phase = "R7";
        en_i = '1;
        load('1);
        cyc(0, 0); cyc(0, 1); cyc(0, 0);

        // R8: back-to-back drains on one register, then both alternating
        phase = "R8";
        fast_i = 64'h00FF_0000_F0F0_000F; prio_i = rnd_prio();
        load('1);
        repeat (66) cyc(1, 0);
        load('1);
        for (int k = 0; k < 70; k++) cyc(1, logic'(k[0]));

        // Random mix
        phase = "random";
        for (int k = 0; k < 4000; k++) begin
            if (k % 16 == 0) begin
                en_i = {$urandom, $urandom} | {$urandom, $urandom};
                fast_i = {$urandom, $urandom} & {$urandom, $urandom};
                prio_i = rnd_prio();
            end
            if (k % 12 == 0) load({$urandom, $urandom} & {$urandom, $urandom});
            cyc(logic'($urandom % 4 != 0), logic'($urandom % 2));
        end

        cyc(0, 0);
        @(posedge clk); #1;
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule